// File: doc/BRIEF.md
# Binary64 Ordered Compare Unit

This block compares two IEEE 754 double-precision operands and reports the outcome as a three-flag code. The carry-style flag `res_c` means "below or unordered". The zero-style flag `res_z` means "equal or unordered". The parity-style flag `res_p` means "unordered". A separate flag `res_inv` reports an invalid operation. Downstream branch logic decodes the code, so the exact flag pattern for each outcome is fixed.

A caller presents `opa`, `opb` and a strobe `in_vld`. One clock later `out_vld` rises together with the registered flags. The control `subn_zero` makes every subnormal input count as a zero of its own sign, at the cost of gradual underflow. Each operand is split into a sign bit (bit 63), an 11-bit exponent (bits 62:52) and a 52-bit fraction (bits 51:0).

Top module: `fp64_order_cmp`

## Requirements
- R1: When opa is greater than opb and neither is NaN, the flags {res_c,res_z,res_p} are 3'b000.
- R2: When opa is less than opb and neither is NaN, the flags are 3'b100: res_c is 1, and res_z and res_p are 0.
- R3: When opa equals opb and neither is NaN, the flags are 3'b010: res_z is 1, and res_c and res_p are 0.
- R4: If either operand is a NaN, all three flags are 1. A NaN has an exponent field (bits 62:52) of all ones and a nonzero fraction (bits 51:0).
- R5: Positive zero (64'h0) and negative zero (64'h8000_0000_0000_0000) compare as equal in every pairing.
- R6: Finite values use sign-magnitude ordering. Any positive value is above any negative value. Between two negative operands, the larger magnitude is the smaller value. Infinities (exponent all ones, fraction zero) lie beyond every finite value.
- R7: When subn_zero is 1, a subnormal input (exponent zero, fraction nonzero) is compared as a zero of its own sign. When subn_zero is 0, the subnormal keeps its value.
- R8: res_inv is 1 only when at least one operand is a signaling NaN, which is a NaN with fraction bit 51 equal to 0. A quiet NaN, which has fraction bit 51 equal to 1, sets the unordered code and leaves res_inv at 0.
- R9: An operand compared with itself gives the unordered code exactly when it is a NaN. Every other value compared with itself gives the equal code.
- R10: out_vld is 1 in the cycle after a cycle with in_vld 1 and is 0 otherwise. The result flags change only on a clock edge where in_vld is 1.
- R11: Reset (rst_n low) clears out_vld and all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands valid this cycle |
| opa | input | 64 | First operand, binary64 |
| opb | input | 64 | Second operand, binary64 |
| subn_zero | input | 1 | Treat subnormal inputs as signed zero |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| res_c | output | 1 | Below-or-unordered flag |
| res_z | output | 1 | Equal-or-unordered flag |
| res_p | output | 1 | Unordered flag |
| res_inv | output | 1 | Invalid operation (signaling NaN input) |

## Verification
Every ordered pair is drawn from a set of sixteen operands and is run with the subnormal control both clear and set. The set holds both zeros, subnormals and normals of each sign, the extremes, both infinities, and quiet and signaling NaNs. Same-sign negative pairs separate correct reversed ordering from plain magnitude compare. Zero-against-zero and subnormal-against-zero pairs separate signed-zero equality and subnormal flushing from bitwise equality. The diagonal pairs exercise the NaN self-test. Quiet and signaling NaNs in either position show that only fraction bit 51 decides res_inv.

// File: rtl/fp64_order_cmp.sv
module fp64_order_cmp #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [EXP_W+FRAC_W:0]   opa,
  input  logic [EXP_W+FRAC_W:0]   opb,
  input  logic                    subn_zero,
  output logic                    out_vld,
  output logic                    res_c,
  output logic                    res_z,
  output logic                    res_p,
  output logic                    res_inv
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic              nan_a, nan_b, snan_a, snan_b;
  logic              sub_a, sub_b;
  logic [MAG_W-1:0]  ma, mb;
  logic              both_zero, mag_gt, mag_eq;
  logic              unord, eq, lt;

  assign {sa, ea, fa} = opa;
  assign {sb, eb, fb} = opb;

  assign nan_a  = (&ea) && (|fa);
  assign nan_b  = (&eb) && (|fb);
  assign snan_a = nan_a && !fa[FRAC_W-1];
  assign snan_b = nan_b && !fb[FRAC_W-1];

  assign sub_a = !(|ea) && (|fa);
  assign sub_b = !(|eb) && (|fb);

  assign ma = (subn_zero && sub_a) ? '0 : {ea, fa};
  assign mb = (subn_zero && sub_b) ? '0 : {eb, fb};

  assign both_zero = (ma == '0) && (mb == '0);
  assign mag_gt    = ma > mb;
  assign mag_eq    = ma == mb;

  assign unord = nan_a || nan_b;
  assign eq    = both_zero || ((sa == sb) && mag_eq);
  assign lt    = !eq && ((sa && !sb) ||
                         (!sa && !sb && !mag_gt) ||
                         (sa && sb && mag_gt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      res_c   <= 1'b0;
      res_z   <= 1'b0;
      res_p   <= 1'b0;
      res_inv <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res_c   <= unord || lt;
        res_z   <= unord || eq;
        res_p   <= unord;
        res_inv <= snan_a || snan_b;
      end
    end
  end
endmodule

// File: rtl/fp64_order_cmp_chk.sv
module fp64_order_cmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        out_vld,
  input logic        res_c,
  input logic        res_z,
  input logic        res_p,
  input logic        res_inv
);
  logic a_is_nan, b_is_nan, a_is_zero, b_is_zero;
  assign a_is_nan  = (opa[62:52] == 11'h7ff) && (opa[51:0] != 52'd0);
  assign b_is_nan  = (opb[62:52] == 11'h7ff) && (opb[51:0] != 52'd0);
  assign a_is_zero = opa[62:0] == 63'd0;
  assign b_is_zero = opb[62:0] == 63'd0;

  // R10
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  // R10
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable({res_c, res_z, res_p, res_inv}));
  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ({res_c, res_z, res_p} inside {3'b000, 3'b100, 3'b010, 3'b111}));
  // R4
  nan_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (a_is_nan || b_is_nan)) |=> (res_c && res_z && res_p));
  // R5
  zero_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && a_is_zero && b_is_zero) |=> (res_z && !res_c && !res_p));
  // R8
  inv_needs_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && res_inv) |-> res_p);
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_vld && !res_c && !res_z && !res_p && !res_inv));
endmodule

bind fp64_order_cmp fp64_order_cmp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb),
  .out_vld(out_vld), .res_c(res_c), .res_z(res_z), .res_p(res_p),
  .res_inv(res_inv)
);

// File: tb/fp64_order_cmp_tb_top.sv
`timescale 1ns/1ps
module fp64_order_cmp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic subn_zero = 1'b0;
  logic out_vld, res_c, res_z, res_p, res_inv;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp64_order_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb),
    .subn_zero(subn_zero), .out_vld(out_vld), .res_c(res_c), .res_z(res_z),
    .res_p(res_p), .res_inv(res_inv)
  );

  function automatic logic [63:0] pick(input int k);
    case (k)
      0:  return 64'h0000_0000_0000_0000;
      1:  return 64'h8000_0000_0000_0000;
      2:  return 64'h0000_0000_0000_0001;
      3:  return 64'h8000_0000_0000_0003;
      4:  return 64'h3ff0_0000_0000_0000;
      5:  return 64'hbff0_0000_0000_0000;
      6:  return 64'h4000_0000_0000_0000;
      7:  return 64'hc000_0000_0000_0000;
      8:  return 64'h7fef_ffff_ffff_ffff;
      9:  return 64'hffef_ffff_ffff_ffff;
      10: return 64'h7ff0_0000_0000_0000;
      11: return 64'hfff0_0000_0000_0000;
      12: return 64'h7ff8_0000_0000_0000;
      13: return 64'h7ff0_0000_0000_0001;
      14: return 64'hfff8_0000_0000_0005;
      default: return 64'h3ff8_0000_0000_0000;
    endcase
  endfunction

  function automatic bit is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7ff) && (v[51:0] != 0);
  endfunction
  function automatic bit is_sub(input logic [63:0] v);
    return (v[62:52] == 0) && (v[51:0] != 0);
  endfunction
  function automatic real value_of(input logic [63:0] v, input bit dz);
    if (dz && is_sub(v)) return 0.0;
    return $bitstoreal(v);
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s opa=%h opb=%h dz=%0b got=%b expected=%b", tag, opa, opb, subn_zero, got, exp);
    end
  endtask

  task automatic run_pair(input logic [63:0] a, input logic [63:0] b, input bit dz, input string forced_tag);
    logic [2:0] want;
    string tag;
    real ra, rb;
    bit nan;
    @(negedge clk);
    opa = a; opb = b; subn_zero = dz; in_vld = 1'b1;
    nan = is_nan(a) || is_nan(b);
    ra = value_of(a, dz); rb = value_of(b, dz);
    if (nan)           begin want = 3'b111; tag = "R4"; end
    else if (ra > rb)  begin want = 3'b000; tag = "R1"; end
    else if (ra < rb)  begin want = 3'b100; tag = "R2"; end
    else               begin want = 3'b010; tag = "R3"; end
    if (!nan) begin
      if (a[62:0] == 0 && b[62:0] == 0) tag = "R5";
      else if (is_sub(a) || is_sub(b)) tag = "R7";
      else if (a[63] || b[63]) tag = "R6";
    end
    if (forced_tag != "") tag = forced_tag;
    @(negedge clk);
    check({tag, " R10 valid"}, {3'b000, out_vld}, 4'b0001);
    check(tag, {1'b0, res_c, res_z, res_p}, {1'b0, want});
    check("R8", {3'b000, res_inv},
          {3'b000, (is_nan(a) && !a[51]) || (is_nan(b) && !b[51])});
    in_vld = 1'b0;
  endtask

  initial begin
    logic [3:0] held;
    repeat (3) @(negedge clk);
    check("R11", {out_vld, res_c, res_z, res_p}, 4'b0000);
    check("R11 inv", {3'b000, res_inv}, 4'b0000);
    rst_n = 1'b1;
    for (int dz = 0; dz < 2; dz++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          run_pair(pick(i), pick(j), dz[0], (i == j) ? "R9" : "");
    run_pair(64'hc000_0000_0000_0000, 64'hbff0_0000_0000_0000, 1'b0, "R6");
    run_pair(64'h8000_0000_0000_0003, 64'h0000_0000_0000_0000, 1'b1, "R7");
    run_pair(64'h8000_0000_0000_0003, 64'h0000_0000_0000_0000, 1'b0, "R7");
    run_pair(64'h7ff0_0000_0000_0001, 64'h3ff0_0000_0000_0000, 1'b0, "R8");
    held = {res_c, res_z, res_p, res_inv};
    @(negedge clk);
    opa = 64'h0; opb = 64'h7ff8_0000_0000_0000;
    @(negedge clk);
    check("R10 idle valid", {3'b000, out_vld}, 4'b0000);
    check("R10 hold", {res_c, res_z, res_p, res_inv}, held);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 again", {out_vld, res_c, res_z, res_p}, 4'b0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule